// File: doc/BRIEF.md
# Snooping Invalidation Coherence Controller

This block keeps one processor's small direct-mapped write-back cache coherent with the other caches on a shared broadcast bus. Every line stores a tag, one data word and one of three coherence states: Invalid, Shared (clean, read-only) or Exclusive (sole copy, dirty, writable). Processor reads and writes that hit finish without using the bus. Misses, and writes to lines that are not Exclusive, stall the processor while the controller wins the bus and issues a write-back, a read miss or a write miss.

The controller also watches every transaction that another cache places on the bus. When it holds the target line it demotes or invalidates the line. When its copy is dirty it supplies the word in the same cycle so that the memory response can be cancelled. There is no upgrade transaction: a write to a Shared line issues a full write miss. Memory sits behind the bus, and the bus has one master at a time, with a grant and a done strobe.

Top module: `snoop_coh_ctrl`

## Requirements
- R1: After reset every line is Invalid and `bus_req_o`, `cpu_ready_o` and `snp_wb_o` are low.
- R2: A read to an Invalid line issues a read miss (bus command 1) for the request address, returns the word on `bus_rdata_i` and leaves the line Shared.
- R3: A write to an Invalid line issues a write miss (bus command 2) and leaves the line Exclusive, holding the written word.
- R4: A write whose tag matches a Shared line issues a write miss with no write-back and leaves the line Exclusive.
- R5: A read whose tag differs from a Shared line issues only a read miss, and the new line is Shared.
- R6: A read whose tag differs from an Exclusive line first writes the old word back (bus command 3, address {old tag, index}), then issues a read miss. The new line is Shared.
- R7: A write whose tag differs from an Exclusive line writes the old word back, then issues a write miss. The new line is Exclusive.
- R8: A read hit in Shared or Exclusive, and a write hit in Exclusive, raise `cpu_ready_o` in the cycle of the request and use no bus transaction.
- R9: A snooped write miss that matches a Shared line makes it Invalid, with no write-back.
- R10: A snooped read miss that matches an Exclusive line raises `snp_wb_o` with the word on `snp_data_o` in the same cycle, and the line becomes Shared.
- R11: A snooped write miss that matches an Exclusive line raises `snp_wb_o` with the word, and the line becomes Invalid.
- R12: Snoops from this cache's own source id, snoops whose full tag differs, and snooped read misses to a Shared line change nothing and do not raise `snp_wb_o`.
- R13: A miss holds `bus_req_o` with a stable command and address until a cycle with both `bus_gnt_i` and `bus_done_i`. `cpu_ready_o` rises one cycle after the final such cycle, and at most one miss is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cpu_req_i | input | 1 | Processor request, held until ready |
| cpu_we_i | input | 1 | 1 = write, 0 = read |
| cpu_addr_i | input | ADDR_W | Word address; low IDX_W bits index the line |
| cpu_wdata_i | input | DATA_W | Write word |
| cpu_ready_o | output | 1 | Request complete |
| cpu_rdata_o | output | DATA_W | Read word, valid with ready |
| bus_req_o | output | 1 | Bus transaction pending |
| bus_gnt_i | input | 1 | Bus granted to this cache |
| bus_done_i | input | 1 | Granted transaction completes this cycle |
| bus_cmd_o | output | 2 | 1 read miss, 2 write miss, 3 write-back |
| bus_addr_o | output | ADDR_W | Transaction address |
| bus_wdata_o | output | DATA_W | Write-back word |
| bus_rdata_i | input | DATA_W | Fill word, valid with done |
| snp_valid_i | input | 1 | Observed bus transaction |
| snp_src_i | input | ID_W | Issuer id of observed transaction |
| snp_cmd_i | input | 2 | Observed command, same encoding |
| snp_addr_i | input | ADDR_W | Observed address |
| snp_wb_o | output | 1 | Dirty copy supplied; memory response cancelled |
| snp_data_o | output | DATA_W | Supplied word |

## Verification
Hit responses are due in the cycle of the request. The bench drives inputs on a falling edge and samples `cpu_ready_o` one time unit later, in that same low phase. Miss responses are due one cycle after the edge that sees grant and done. The bench therefore polls ready at each falling edge, and in every wait cycle it checks that the request stays asserted and the processor stays stalled. Snoop write-back outputs are sampled in the snoop's own cycle, because they are combinational. A state change caused by a snoop becomes visible from the next edge, and the bench shows it through the bus traffic of a later processor access, which is compared against a queue of expected transactions.

// File: rtl/coh_pkg.sv
package coh_pkg;
  typedef enum logic [1:0] {LN_INV = 2'd0, LN_SHR = 2'd1, LN_EXC = 2'd2} line_st_e;
  typedef enum logic [1:0] {
    BC_NONE = 2'd0, BC_RDMISS = 2'd1, BC_WRMISS = 2'd2, BC_WBACK = 2'd3
  } bus_cmd_e;
endpackage

// File: rtl/coh_line_store.sv
module coh_line_store
  import coh_pkg::*;
#(
  parameter int unsigned TAG_W  = 13,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IDX_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  lk_idx_i,
  output logic [TAG_W-1:0]  lk_tag_o,
  output logic [DATA_W-1:0] lk_data_o,
  output line_st_e          lk_st_o,
  input  logic [IDX_W-1:0]  sn_idx_i,
  output logic [TAG_W-1:0]  sn_tag_o,
  output logic [DATA_W-1:0] sn_data_o,
  output line_st_e          sn_st_o,
  input  logic              sn_we_i,
  input  line_st_e          sn_st_i,
  input  logic              fill_we_i,
  input  logic [IDX_W-1:0]  fill_idx_i,
  input  logic [TAG_W-1:0]  fill_tag_i,
  input  logic [DATA_W-1:0] fill_data_i,
  input  line_st_e          fill_st_i,
  input  logic              hit_we_i,
  input  logic [IDX_W-1:0]  hit_idx_i,
  input  logic [DATA_W-1:0] hit_data_i
);
  localparam int unsigned LINES = 1 << IDX_W;

  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [DATA_W-1:0] data_q [LINES];
  line_st_e          st_q   [LINES];

  assign lk_tag_o  = tag_q[lk_idx_i];
  assign lk_data_o = data_q[lk_idx_i];
  assign lk_st_o   = st_q[lk_idx_i];
  assign sn_tag_o  = tag_q[sn_idx_i];
  assign sn_data_o = data_q[sn_idx_i];
  assign sn_st_o   = st_q[sn_idx_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < LINES; i++) begin
        st_q[i]   <= LN_INV;
        tag_q[i]  <= '0;
        data_q[i] <= '0;
      end
    end else begin
      if (sn_we_i) st_q[sn_idx_i] <= sn_st_i;
      if (fill_we_i) begin
        tag_q[fill_idx_i]  <= fill_tag_i;
        data_q[fill_idx_i] <= fill_data_i;
        st_q[fill_idx_i]   <= fill_st_i;
      end
      if (hit_we_i) data_q[hit_idx_i] <= hit_data_i;
    end
  end

  // snoop and local update never touch one line together
  assert_no_update_clash_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sn_we_i |-> !((fill_we_i && fill_idx_i == sn_idx_i) || (hit_we_i && hit_idx_i == sn_idx_i)));
endmodule

// File: rtl/coh_snoop.sv
module coh_snoop
  import coh_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IDX_W  = 3,
  parameter int unsigned ID_W   = 2,
  parameter logic [ID_W-1:0] CACHE_ID = '0,
  localparam int unsigned TAG_W = ADDR_W - IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              snp_valid_i,
  input  logic [ID_W-1:0]   snp_src_i,
  input  logic [1:0]        snp_cmd_i,
  input  logic [ADDR_W-1:0] snp_addr_i,
  output logic [IDX_W-1:0]  sn_idx_o,
  input  logic [TAG_W-1:0]  sn_tag_i,
  input  logic [DATA_W-1:0] sn_data_i,
  input  line_st_e          sn_st_i,
  output logic              sn_we_o,
  output line_st_e          sn_st_o,
  output logic              snp_wb_o,
  output logic [DATA_W-1:0] snp_data_o
);
  logic foreign, match, is_rd, is_wr;

  assign sn_idx_o = snp_addr_i[IDX_W-1:0];
  assign foreign  = snp_valid_i && (snp_src_i != CACHE_ID);
  assign match    = foreign && (sn_st_i != LN_INV) && (sn_tag_i == snp_addr_i[ADDR_W-1:IDX_W]);
  assign is_rd    = snp_cmd_i == BC_RDMISS;
  assign is_wr    = snp_cmd_i == BC_WRMISS;

  always_comb begin
    sn_we_o  = 1'b0;
    sn_st_o  = sn_st_i;
    snp_wb_o = 1'b0;
    if (match && sn_st_i == LN_EXC && (is_rd || is_wr)) begin
      snp_wb_o = 1'b1;
      sn_we_o  = 1'b1;
      sn_st_o  = is_rd ? LN_SHR : LN_INV;
    end else if (match && sn_st_i == LN_SHR && is_wr) begin
      sn_we_o = 1'b1;
      sn_st_o = LN_INV;
    end
  end

  assign snp_data_o = sn_data_i;

  assert_own_ignored_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snp_valid_i && snp_src_i == CACHE_ID) |-> (!sn_we_o && !snp_wb_o));

  assert_wb_leaves_exc_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_wb_o |-> (sn_we_o && sn_st_o != LN_EXC));
endmodule

// File: rtl/coh_miss_fsm.sv
module coh_miss_fsm
  import coh_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IDX_W  = 3,
  localparam int unsigned TAG_W = ADDR_W - IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic              cpu_ready_o,
  output logic [DATA_W-1:0] cpu_rdata_o,
  input  logic              stall_i,
  input  logic [TAG_W-1:0]  lk_tag_i,
  input  logic [DATA_W-1:0] lk_data_i,
  input  line_st_e          lk_st_i,
  output logic              bus_req_o,
  input  logic              bus_gnt_i,
  input  logic              bus_done_i,
  output logic [1:0]        bus_cmd_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  input  logic [DATA_W-1:0] bus_rdata_i,
  output logic              fill_we_o,
  output logic [IDX_W-1:0]  fill_idx_o,
  output logic [TAG_W-1:0]  fill_tag_o,
  output logic [DATA_W-1:0] fill_data_o,
  output line_st_e          fill_st_o,
  output logic              hit_we_o,
  output logic [IDX_W-1:0]  hit_idx_o,
  output logic [DATA_W-1:0] hit_data_o
);
  typedef enum logic [1:0] {ST_IDLE, ST_WB, ST_MISS, ST_RESP} fsm_st_e;

  fsm_st_e           st_q, st_d;
  logic [ADDR_W-1:0] addr_q;
  logic              we_q;
  logic [DATA_W-1:0] wdata_q, vic_data_q, rdata_q;
  logic [TAG_W-1:0]  vic_tag_q;

  logic tag_eq, rd_hit, wr_hit, hit, miss, need_wb, xfer_end;

  assign tag_eq   = (lk_st_i != LN_INV) && (lk_tag_i == cpu_addr_i[ADDR_W-1:IDX_W]);
  assign rd_hit   = !cpu_we_i && tag_eq;
  assign wr_hit   = cpu_we_i && tag_eq && (lk_st_i == LN_EXC);
  assign hit      = (st_q == ST_IDLE) && cpu_req_i && !stall_i && (rd_hit || wr_hit);
  assign miss     = (st_q == ST_IDLE) && cpu_req_i && !stall_i && !(rd_hit || wr_hit);
  assign need_wb  = (lk_st_i == LN_EXC) && !tag_eq;
  assign xfer_end = bus_gnt_i && bus_done_i;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (miss) st_d = need_wb ? ST_WB : ST_MISS;
      ST_WB:   if (xfer_end) st_d = ST_MISS;
      ST_MISS: if (xfer_end) st_d = ST_RESP;
      ST_RESP: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      addr_q     <= '0;
      we_q       <= 1'b0;
      wdata_q    <= '0;
      vic_tag_q  <= '0;
      vic_data_q <= '0;
      rdata_q    <= '0;
    end else begin
      st_q <= st_d;
      if (miss) begin
        addr_q     <= cpu_addr_i;
        we_q       <= cpu_we_i;
        wdata_q    <= cpu_wdata_i;
        vic_tag_q  <= lk_tag_i;
        vic_data_q <= lk_data_i;
      end
      if (st_q == ST_MISS && xfer_end) rdata_q <= fill_data_o;
    end
  end

  always_comb begin
    bus_req_o   = 1'b0;
    bus_cmd_o   = BC_NONE;
    bus_addr_o  = addr_q;
    bus_wdata_o = vic_data_q;
    if (st_q == ST_WB) begin
      bus_req_o  = 1'b1;
      bus_cmd_o  = BC_WBACK;
      bus_addr_o = {vic_tag_q, addr_q[IDX_W-1:0]};
    end else if (st_q == ST_MISS) begin
      bus_req_o = 1'b1;
      bus_cmd_o = we_q ? BC_WRMISS : BC_RDMISS;
    end
  end

  assign fill_we_o   = (st_q == ST_MISS) && xfer_end;
  assign fill_idx_o  = addr_q[IDX_W-1:0];
  assign fill_tag_o  = addr_q[ADDR_W-1:IDX_W];
  assign fill_data_o = we_q ? wdata_q : bus_rdata_i;
  assign fill_st_o   = we_q ? LN_EXC : LN_SHR;

  assign hit_we_o   = hit && cpu_we_i;
  assign hit_idx_o  = cpu_addr_i[IDX_W-1:0];
  assign hit_data_o = cpu_wdata_i;

  assign cpu_ready_o = hit || (st_q == ST_RESP);
  assign cpu_rdata_o = (st_q == ST_RESP) ? rdata_q : lk_data_i;

  assert_cmd_hold_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !xfer_end) |=> (bus_req_o && $stable(bus_cmd_o) && $stable(bus_addr_o)));

  assert_ready_after_done_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RESP) |-> $past(bus_gnt_i && bus_done_i));

  assert_wb_then_miss_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && bus_cmd_o == BC_WBACK && xfer_end) |=>
      (bus_req_o && (bus_cmd_o == BC_RDMISS || bus_cmd_o == BC_WRMISS)));

  assert_hit_no_bus_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_ready_o && st_q == ST_IDLE) |=> !bus_req_o);
endmodule

// File: rtl/snoop_coh_ctrl.sv
module snoop_coh_ctrl
  import coh_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IDX_W  = 3,
  parameter int unsigned ID_W   = 2,
  parameter logic [ID_W-1:0] CACHE_ID = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic              cpu_ready_o,
  output logic [DATA_W-1:0] cpu_rdata_o,
  output logic              bus_req_o,
  input  logic              bus_gnt_i,
  input  logic              bus_done_i,
  output logic [1:0]        bus_cmd_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  input  logic [DATA_W-1:0] bus_rdata_i,
  input  logic              snp_valid_i,
  input  logic [ID_W-1:0]   snp_src_i,
  input  logic [1:0]        snp_cmd_i,
  input  logic [ADDR_W-1:0] snp_addr_i,
  output logic              snp_wb_o,
  output logic [DATA_W-1:0] snp_data_o
);
  localparam int unsigned TAG_W = ADDR_W - IDX_W;

  logic [TAG_W-1:0]  lk_tag, sn_tag, fill_tag;
  logic [DATA_W-1:0] lk_data, sn_data, fill_data, hit_data;
  line_st_e          lk_st, sn_st, sn_st_new, fill_st;
  logic [IDX_W-1:0]  sn_idx, fill_idx, hit_idx;
  logic              sn_we, fill_we, hit_we, stall;

  // a snoop rewriting the line the processor addresses holds the processor off
  assign stall = sn_we && (sn_idx == cpu_addr_i[IDX_W-1:0]);

  coh_line_store #(.TAG_W(TAG_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) i_store (
    .clk_i, .rst_ni,
    .lk_idx_i(cpu_addr_i[IDX_W-1:0]), .lk_tag_o(lk_tag), .lk_data_o(lk_data), .lk_st_o(lk_st),
    .sn_idx_i(sn_idx), .sn_tag_o(sn_tag), .sn_data_o(sn_data), .sn_st_o(sn_st),
    .sn_we_i(sn_we), .sn_st_i(sn_st_new),
    .fill_we_i(fill_we), .fill_idx_i(fill_idx), .fill_tag_i(fill_tag),
    .fill_data_i(fill_data), .fill_st_i(fill_st),
    .hit_we_i(hit_we), .hit_idx_i(hit_idx), .hit_data_i(hit_data)
  );

  coh_snoop #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .ID_W(ID_W),
              .CACHE_ID(CACHE_ID)) i_snoop (
    .clk_i, .rst_ni,
    .snp_valid_i, .snp_src_i, .snp_cmd_i, .snp_addr_i,
    .sn_idx_o(sn_idx), .sn_tag_i(sn_tag), .sn_data_i(sn_data), .sn_st_i(sn_st),
    .sn_we_o(sn_we), .sn_st_o(sn_st_new), .snp_wb_o, .snp_data_o
  );

  coh_miss_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) i_fsm (
    .clk_i, .rst_ni,
    .cpu_req_i, .cpu_we_i, .cpu_addr_i, .cpu_wdata_i, .cpu_ready_o, .cpu_rdata_o,
    .stall_i(stall), .lk_tag_i(lk_tag), .lk_data_i(lk_data), .lk_st_i(lk_st),
    .bus_req_o, .bus_gnt_i, .bus_done_i, .bus_cmd_o, .bus_addr_o, .bus_wdata_o, .bus_rdata_i,
    .fill_we_o(fill_we), .fill_idx_o(fill_idx), .fill_tag_o(fill_tag),
    .fill_data_o(fill_data), .fill_st_o(fill_st),
    .hit_we_o(hit_we), .hit_idx_o(hit_idx), .hit_data_o(hit_data)
  );

  assert_reset_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (!bus_req_o && !cpu_ready_o));
endmodule

// File: tb/test_snoop_coh_ctrl.sv
`timescale 1ns/100ps
module test_snoop_coh_ctrl;
  localparam int CMD_RD = 1, CMD_WR = 2, CMD_WB = 3;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cpu_req = 0, cpu_we = 0;
  logic [15:0] cpu_addr = '0;
  logic [31:0] cpu_wdata = '0;
  logic        cpu_ready;
  logic [31:0] cpu_rdata;
  logic        bus_req, bus_gnt = 0, bus_done = 0;
  logic [1:0]  bus_cmd;
  logic [15:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata = '0;
  logic        snp_valid = 0;
  logic [1:0]  snp_src = '0, snp_cmd = '0;
  logic [15:0] snp_addr = '0;
  logic        snp_wb;
  logic [31:0] snp_data;

  always #2.5 clk = ~clk;

  snoop_coh_ctrl i_snoop_coh_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .cpu_req_i(cpu_req), .cpu_we_i(cpu_we), .cpu_addr_i(cpu_addr), .cpu_wdata_i(cpu_wdata),
    .cpu_ready_o(cpu_ready), .cpu_rdata_o(cpu_rdata),
    .bus_req_o(bus_req), .bus_gnt_i(bus_gnt), .bus_done_i(bus_done), .bus_cmd_o(bus_cmd),
    .bus_addr_o(bus_addr), .bus_wdata_o(bus_wdata), .bus_rdata_i(bus_rdata),
    .snp_valid_i(snp_valid), .snp_src_i(snp_src), .snp_cmd_i(snp_cmd), .snp_addr_i(snp_addr),
    .snp_wb_o(snp_wb), .snp_data_o(snp_data)
  );

  typedef struct { int cmd; logic [15:0] addr; logic [31:0] data; string req; } txn_t;
  txn_t exp_q[$];
  logic [31:0] mem [int];
  int checks = 0, errors = 0;
  bit done_flag = 0;

  function automatic logic [31:0] mem_rd(logic [15:0] a);
    return mem.exists(int'(a)) ? mem[int'(a)] : {16'hBEEF, a};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic expect_txn(int cmd, logic [15:0] a, logic [31:0] d, string req);
    txn_t t;
    t.cmd = cmd; t.addr = a; t.data = d; t.req = req;
    exp_q.push_back(t);
  endtask

  // bus responder and monitor: two stall cycles, then grant with done
  initial begin
    forever begin
      @(negedge clk);
      if (bus_req === 1'b1) begin
        automatic int          c = int'(bus_cmd);
        automatic logic [15:0] a = bus_addr;
        automatic logic [31:0] d = bus_wdata;
        if (exp_q.size() == 0) begin
          chk("R13 unexpected bus txn cmd", 32'(c), 32'd0);
        end else begin
          automatic txn_t e = exp_q.pop_front();
          chk({e.req, " bus cmd"}, 32'(c), 32'(e.cmd));
          chk({e.req, " bus addr"}, 32'(a), 32'(e.addr));
          if (e.cmd == CMD_WB) chk({e.req, " write-back data"}, d, e.data);
        end
        for (int k = 0; k < 2; k++) begin
          @(negedge clk);
          chk("R13 request held while ungranted", {31'd0, bus_req}, 32'd1);
          chk("R13 command stable", {30'd0, bus_cmd}, 32'(c));
          chk("R13 processor stalled", {31'd0, cpu_ready}, 32'd0);
        end
        if (c == CMD_WB) mem[int'(a)] = d;
        bus_rdata = mem_rd(a);
        bus_gnt = 1; bus_done = 1;
        @(negedge clk);
        bus_gnt = 0; bus_done = 0;
      end
    end
  end

  task automatic cpu_op(bit we, logic [15:0] a, logic [31:0] wd, logic [31:0] exp_rd,
                        bit exp_hit, string req);
    int n = 0;
    @(negedge clk);
    cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    #1;
    if (exp_hit) chk({req, " ready in request cycle"}, {31'd0, cpu_ready}, 32'd1);
    while (!cpu_ready && n < 200) begin
      @(negedge clk); #1; n++;
    end
    if (!we) chk({req, " read data"}, cpu_rdata, exp_rd);
    @(negedge clk);
    cpu_req = 0;
    chk({req, " pending bus txns"}, 32'(exp_q.size()), 32'd0);
  endtask

  task automatic snoop(logic [1:0] src, int cmd, logic [15:0] a, bit exp_wb,
                       logic [31:0] exp_d, string req);
    @(negedge clk);
    snp_valid = 1; snp_src = src; snp_cmd = 2'(cmd); snp_addr = a;
    #1;
    chk({req, " snoop write-back"}, {31'd0, snp_wb}, {31'd0, exp_wb});
    if (exp_wb) begin
      chk({req, " snoop data"}, snp_data, exp_d);
      mem[int'(a)] = snp_data;
    end
    @(negedge clk);
    snp_valid = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done_flag) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R1 bus_req after reset", {31'd0, bus_req}, 32'd0);
    chk("R1 ready after reset", {31'd0, cpu_ready}, 32'd0);
    rst_n = 1;
    @(negedge clk); #1;
    chk("R1 snoop output idle", {31'd0, snp_wb}, 32'd0);

    // idx0: A=0010 (tag 2), B=0020 (tag 4), C=0028 (tag 5)
    expect_txn(CMD_RD, 16'h0010, 0, "R2");
    cpu_op(0, 16'h0010, 0, 32'hBEEF0010, 0, "R2 read Invalid");
    cpu_op(0, 16'h0010, 0, 32'hBEEF0010, 1, "R8 read hit Shared");
    expect_txn(CMD_WR, 16'h0010, 0, "R4");
    cpu_op(1, 16'h0010, 32'h1111_1111, 0, 0, "R4 write Shared");
    cpu_op(0, 16'h0010, 0, 32'h1111_1111, 1, "R8 read hit Exclusive");
    expect_txn(CMD_WB, 16'h0010, 32'h1111_1111, "R6");
    expect_txn(CMD_RD, 16'h0020, 0, "R6");
    cpu_op(0, 16'h0020, 0, 32'hBEEF0020, 0, "R6 read over Exclusive");
    chk("R6 memory holds written-back word", mem_rd(16'h0010), 32'h1111_1111);
    expect_txn(CMD_RD, 16'h0028, 0, "R5");
    cpu_op(0, 16'h0028, 0, 32'hBEEF0028, 0, "R5 read over Shared");
    cpu_op(0, 16'h0028, 0, 32'hBEEF0028, 1, "R5 new line Shared hit");

    // idx1: D=0041 (tag 8), E=0049 (tag 9), F=0051 (tag 10)
    expect_txn(CMD_WR, 16'h0041, 0, "R3");
    cpu_op(1, 16'h0041, 32'h4444_4444, 0, 0, "R3 write Invalid");
    cpu_op(0, 16'h0041, 0, 32'h4444_4444, 1, "R3 written word held");
    expect_txn(CMD_WB, 16'h0041, 32'h4444_4444, "R7");
    expect_txn(CMD_WR, 16'h0049, 0, "R7");
    cpu_op(1, 16'h0049, 32'h5555_5555, 0, 0, "R7 write over Exclusive");
    cpu_op(1, 16'h0049, 32'h6666_6666, 0, 1, "R8 write hit Exclusive");
    cpu_op(0, 16'h0049, 0, 32'h6666_6666, 1, "R7 line stays Exclusive");

    snoop(2'd2, CMD_RD, 16'h0049, 1, 32'h6666_6666, "R10 snooped read on Exclusive");
    expect_txn(CMD_WR, 16'h0049, 0, "R10");
    cpu_op(1, 16'h0049, 32'h7777_7777, 0, 0, "R10 line now Shared");

    snoop(2'd0, CMD_WR, 16'h0049, 0, 0, "R12 own-source snoop");
    cpu_op(0, 16'h0049, 0, 32'h7777_7777, 1, "R12 own snoop ignored");

    snoop(2'd1, CMD_WR, 16'h0049, 1, 32'h7777_7777, "R11 snooped write on Exclusive");
    expect_txn(CMD_RD, 16'h0049, 0, "R11");
    cpu_op(0, 16'h0049, 0, 32'h7777_7777, 0, "R11 line now Invalid");

    snoop(2'd1, CMD_WR, 16'h0051, 0, 0, "R12 tag mismatch snoop");
    cpu_op(0, 16'h0049, 0, 32'h7777_7777, 1, "R12 mismatch ignored");
    snoop(2'd3, CMD_RD, 16'h0049, 0, 0, "R12 snooped read on Shared");
    cpu_op(0, 16'h0049, 0, 32'h7777_7777, 1, "R12 Shared kept");

    snoop(2'd1, CMD_WR, 16'h0049, 0, 0, "R9 snooped write on Shared");
    expect_txn(CMD_RD, 16'h0049, 0, "R9");
    cpu_op(0, 16'h0049, 0, 32'h7777_7777, 0, "R9 line now Invalid");

    repeat (3) @(negedge clk);
    done_flag = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule